// File: doc/BRIEF.md
# Dual-Hash Tagged Target Table

This block is a single tagged table inside an indirect-branch target predictor. Each row stores a partial tag, a predicted target, a 2-bit confidence counter and a 2-bit replacement counter. Rows are found by one of two hash pairs. In history mode, the index and the tag mix the branch address with folded global history, so that one branch can own several rows. In address mode, only the branch address is used, so that the table behaves like a plain target buffer. The `mode_addr` input picks the pair. It applies to lookups and to updates alike, and it can change at any time without disturbing the stored rows.

The fetch side sends a lookup beat (PC plus history) on a valid/ready channel. The response comes back on a second valid/ready channel one cycle after the beat is taken. A lookup is accepted only when the response register is empty or is being drained in the same cycle. While `rsp_ready` is low, a pending response holds its value and no new lookup is taken. The retire side sends update or allocate beats on a third channel, which is always ready. Each beat carries the resolved target and the outcome of the alternate prediction.

Top module: `dual_hash_target_table`

## Requirements
- R1: After reset every row is invalid. `rsp_valid` is low, `lk_ready` and `up_ready` are high, and any lookup misses.
- R2: A response reports `rsp_hit`=1 only when the indexed row is valid and its stored tag equals the computed tag. On a miss, `rsp_target`, `rsp_conf` and `rsp_repl` are all zero.
- R3: In history mode (`mode_addr`=0), fold(h,w) is the XOR of consecutive w-bit chunks of the history, starting at bit 0, with the last chunk zero-padded. The index is (pc>>2) XOR fold(hist,IDX_W) and the tag is (pc>>2) XOR fold(hist,TAG_W), each cut to its width.
- R4: In address mode (`mode_addr`=1), the index is (pc>>2) cut to IDX_W bits and the tag is (pc>>(2+IDX_W)) cut to TAG_W bits. The history is ignored.
- R5: An allocate beat (`up_alloc`=1) writes the computed tag and `up_target` into the computed row, marks it valid, and sets confidence and replacement to 0.
- R6: An update beat (`up_alloc`=0) that hits changes the confidence counter. The counter goes up by one, saturating at 3, when the stored target equals `up_target`, and down by one otherwise. When it is wrong while confidence is already 0, the stored target is replaced by `up_target` and confidence stays 0. In all other cases the stored target is unchanged.
- R7: In history mode, a hitting update changes the replacement counter only when `up_alt_diff`=1. The counter then goes up by one (saturating at 3) if the row's target was correct. Otherwise, it goes down by one (saturating at 0) if `up_alt_ok`=1.
- R8: In address mode, every hitting update raises the replacement counter by one, saturating at 3, whatever the alternate inputs say.
- R9: An update beat (`up_alloc`=0) whose row is invalid or whose stored tag differs from the computed tag changes nothing.
- R10: The read is registered. A lookup and a write to the same row on the same edge return the row's contents from before that write.
- R11: While `rsp_valid`=1 and `rsp_ready`=0, `lk_ready` is 0 and all response outputs hold their values.
- R12: Switching `mode_addr` clears no row. A row written in one mode is found again when the same mode is selected later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_addr | input | 1 | 0: history hashing, 1: address-only hashing |
| lk_valid | input | 1 | Lookup beat present |
| lk_ready | output | 1 | Lookup beat accepted |
| lk_pc | input | PC_W | Lookup branch address |
| lk_hist | input | HIST_W | Lookup global history |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_hit | output | 1 | Tag matched on a valid row |
| rsp_target | output | TGT_W | Predicted target (0 on miss) |
| rsp_conf | output | 2 | Confidence (0 on miss) |
| rsp_repl | output | 2 | Replacement value (0 on miss) |
| up_valid | input | 1 | Update/allocate beat present |
| up_ready | output | 1 | Always 1 |
| up_alloc | input | 1 | 1: allocate, 0: update |
| up_pc | input | PC_W | Resolved branch address |
| up_hist | input | HIST_W | History at prediction time |
| up_target | input | TGT_W | Resolved target |
| up_alt_diff | input | 1 | Alternate prediction differed from this row |
| up_alt_ok | input | 1 | Alternate prediction was correct |

## Verification
The assertions assume that an update beat names a row that the predictor actually used. They also assume that `mode_addr` is the same for a beat's lookup and its update. The bench does not promise either, so the checks compare the design against a model that follows R9 and applies whatever mode is present at each beat. The checks on counters, held responses and read-before-write hold for any input sequence. The random stimulus draws PCs and histories from small pools, so that rows are hit again and again, counters reach both saturation limits, and index collisions between different tags occur. Directed cases then place a lookup and a write on the same edge and hold `rsp_ready` low.

// File: rtl/ttt_pkg.sv
package ttt_pkg;
  localparam int unsigned CTR_W   = 2;
  localparam logic [1:0]  CTR_MAX = 2'd3;
  localparam logic [1:0]  CTR_MIN = 2'd0;

  typedef logic [CTR_W-1:0] ctr_t;

  function automatic ctr_t ctr_up(input ctr_t c);
    return (c == CTR_MAX) ? c : c + ctr_t'(1);
  endfunction

  function automatic ctr_t ctr_dn(input ctr_t c);
    return (c == CTR_MIN) ? c : c - ctr_t'(1);
  endfunction
endpackage

// File: rtl/ttt_hash.sv
module ttt_hash #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned HIST_W = 40,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned TAG_W  = 13
) (
  input  logic              mode_addr,
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  localparam int unsigned NCH_I = (HIST_W + IDX_W - 1) / IDX_W;
  localparam int unsigned NCH_T = (HIST_W + TAG_W - 1) / TAG_W;

  logic [NCH_I*IDX_W-1:0] pad_i;
  logic [NCH_T*TAG_W-1:0] pad_t;
  logic [IDX_W-1:0]       fold_i;
  logic [TAG_W-1:0]       fold_t;
  logic [PC_W-1:0]        pc_lo, pc_hi;

  assign pad_i = {{(NCH_I*IDX_W-HIST_W){1'b0}}, hist};
  assign pad_t = {{(NCH_T*TAG_W-HIST_W){1'b0}}, hist};
  assign pc_lo = pc >> 2;
  assign pc_hi = pc >> (2 + IDX_W);

  // One XOR stage per history chunk
  logic [IDX_W-1:0] acc_i [NCH_I+1];
  logic [TAG_W-1:0] acc_t [NCH_T+1];
  assign acc_i[0] = '0;
  assign acc_t[0] = '0;

  for (genvar k = 0; k < NCH_I; k++) begin : g_fold_i
    assign acc_i[k+1] = acc_i[k] ^ pad_i[k*IDX_W +: IDX_W];
  end
  for (genvar k = 0; k < NCH_T; k++) begin : g_fold_t
    assign acc_t[k+1] = acc_t[k] ^ pad_t[k*TAG_W +: TAG_W];
  end

  assign fold_i = acc_i[NCH_I];
  assign fold_t = acc_t[NCH_T];

  always_comb begin
    if (mode_addr) begin
      idx = pc_lo[IDX_W-1:0];
      tag = pc_hi[TAG_W-1:0];
    end else begin
      idx = pc_lo[IDX_W-1:0] ^ fold_i;
      tag = pc_lo[TAG_W-1:0] ^ fold_t;
    end
  end
endmodule

// File: rtl/ttt_store.sv
module ttt_store
  import ttt_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned TAG_W = 13,
  parameter int unsigned TGT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  // registered lookup read
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_v,
  output logic [TAG_W-1:0] rd_tag,
  output logic [TGT_W-1:0] rd_tgt,
  output ctr_t             rd_conf,
  output ctr_t             rd_repl,
  // update-side view of the addressed row
  input  logic [IDX_W-1:0] up_idx,
  output logic             up_v,
  output logic [TAG_W-1:0] up_tag,
  output logic [TGT_W-1:0] up_tgt,
  output ctr_t             up_conf,
  output ctr_t             up_repl,
  // write
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TGT_W-1:0] wr_tgt,
  input  ctr_t             wr_conf,
  input  ctr_t             wr_repl
);
  logic [DEPTH-1:0] vld;
  logic [TAG_W-1:0] tag_m  [DEPTH];
  logic [TGT_W-1:0] tgt_m  [DEPTH];
  ctr_t             conf_m [DEPTH];
  ctr_t             repl_m [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) vld <= '0;
    else if (wr_en) vld[up_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_m[up_idx]  <= wr_tag;
      tgt_m[up_idx]  <= wr_tgt;
      conf_m[up_idx] <= wr_conf;
      repl_m[up_idx] <= wr_repl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_v    <= 1'b0;
      rd_tag  <= '0;
      rd_tgt  <= '0;
      rd_conf <= '0;
      rd_repl <= '0;
    end else if (rd_en) begin
      rd_v    <= vld[rd_idx];
      rd_tag  <= tag_m[rd_idx];
      rd_tgt  <= tgt_m[rd_idx];
      rd_conf <= conf_m[rd_idx];
      rd_repl <= repl_m[rd_idx];
    end
  end

  assign up_v    = vld[up_idx];
  assign up_tag  = tag_m[up_idx];
  assign up_tgt  = tgt_m[up_idx];
  assign up_conf = conf_m[up_idx];
  assign up_repl = repl_m[up_idx];

  // A written row is valid from the next cycle on
  assert_wr_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld[$past(up_idx)]);

  // A read of a row not being written returns that row's prior valid bit
  assert_rd_old_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !(wr_en && up_idx == rd_idx)) |=> rd_v == vld[$past(rd_idx)]);
endmodule

// File: rtl/ttt_upd.sv
module ttt_upd
  import ttt_pkg::*;
#(
  parameter int unsigned TAG_W = 13,
  parameter int unsigned TGT_W = 32
) (
  input  logic             fire,
  input  logic             mode_addr,
  input  logic             alloc,
  input  logic [TAG_W-1:0] new_tag,
  input  logic [TGT_W-1:0] res_tgt,
  input  logic             alt_diff,
  input  logic             alt_ok,
  input  logic             old_v,
  input  logic [TAG_W-1:0] old_tag,
  input  logic [TGT_W-1:0] old_tgt,
  input  ctr_t             old_conf,
  input  ctr_t             old_repl,
  output logic             wr_en,
  output logic [TAG_W-1:0] wr_tag,
  output logic [TGT_W-1:0] wr_tgt,
  output ctr_t             wr_conf,
  output ctr_t             wr_repl
);
  logic hit, right;
  ctr_t repl_hist;

  assign hit   = old_v && (old_tag == new_tag);
  assign right = (old_tgt == res_tgt);

  always_comb begin
    repl_hist = old_repl;
    if (alt_diff) begin
      if (right)       repl_hist = ctr_up(old_repl);
      else if (alt_ok) repl_hist = ctr_dn(old_repl);
    end
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_tag  = new_tag;
    wr_tgt  = old_tgt;
    wr_conf = old_conf;
    wr_repl = old_repl;
    if (fire && alloc) begin
      wr_en   = 1'b1;
      wr_tgt  = res_tgt;
      wr_conf = CTR_MIN;
      wr_repl = CTR_MIN;
    end else if (fire && hit) begin
      wr_en = 1'b1;
      if (right) begin
        wr_conf = ctr_up(old_conf);
      end else if (old_conf == CTR_MIN) begin
        wr_tgt  = res_tgt;
      end else begin
        wr_conf = ctr_dn(old_conf);
      end
      wr_repl = mode_addr ? ctr_up(old_repl) : repl_hist;
    end
  end
endmodule

// File: rtl/dual_hash_target_table.sv
module dual_hash_target_table
  import ttt_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned TAG_W  = 13,
  parameter int unsigned HIST_W = 40,
  parameter int unsigned PC_W   = 32,
  parameter int unsigned TGT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_addr,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [HIST_W-1:0] lk_hist,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [TGT_W-1:0]  rsp_target,
  output logic [1:0]        rsp_conf,
  output logic [1:0]        rsp_repl,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic              up_alloc,
  input  logic [PC_W-1:0]   up_pc,
  input  logic [HIST_W-1:0] up_hist,
  input  logic [TGT_W-1:0]  up_target,
  input  logic              up_alt_diff,
  input  logic              up_alt_ok
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag, tag_q;
  logic             lk_fire, up_fire, rsp_q;

  logic             rd_v, o_v;
  logic [TAG_W-1:0] rd_tag, o_tag;
  logic [TGT_W-1:0] rd_tgt, o_tgt;
  ctr_t             rd_conf, rd_repl, o_conf, o_repl;

  logic             wr_en;
  logic [TAG_W-1:0] wr_tag;
  logic [TGT_W-1:0] wr_tgt;
  ctr_t             wr_conf, wr_repl;

  ttt_hash #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_hash_lk (
    .mode_addr(mode_addr), .pc(lk_pc), .hist(lk_hist), .idx(lk_idx), .tag(lk_tag));

  ttt_hash #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_hash_up (
    .mode_addr(mode_addr), .pc(up_pc), .hist(up_hist), .idx(up_idx), .tag(up_tag));

  assign lk_ready = !rsp_q || rsp_ready;
  assign lk_fire  = lk_valid && lk_ready;
  assign up_ready = 1'b1;
  assign up_fire  = up_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_q <= 1'b0;
      tag_q <= '0;
    end else begin
      if (lk_fire) begin
        rsp_q <= 1'b1;
        tag_q <= lk_tag;
      end else if (rsp_ready) begin
        rsp_q <= 1'b0;
      end
    end
  end

  ttt_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_en(lk_fire), .rd_idx(lk_idx),
    .rd_v(rd_v), .rd_tag(rd_tag), .rd_tgt(rd_tgt), .rd_conf(rd_conf), .rd_repl(rd_repl),
    .up_idx(up_idx),
    .up_v(o_v), .up_tag(o_tag), .up_tgt(o_tgt), .up_conf(o_conf), .up_repl(o_repl),
    .wr_en(wr_en), .wr_tag(wr_tag), .wr_tgt(wr_tgt), .wr_conf(wr_conf), .wr_repl(wr_repl));

  ttt_upd #(.TAG_W(TAG_W), .TGT_W(TGT_W)) u_upd (
    .fire(up_fire), .mode_addr(mode_addr), .alloc(up_alloc),
    .new_tag(up_tag), .res_tgt(up_target),
    .alt_diff(up_alt_diff), .alt_ok(up_alt_ok),
    .old_v(o_v), .old_tag(o_tag), .old_tgt(o_tgt), .old_conf(o_conf), .old_repl(o_repl),
    .wr_en(wr_en), .wr_tag(wr_tag), .wr_tgt(wr_tgt), .wr_conf(wr_conf), .wr_repl(wr_repl));

  assign rsp_valid  = rsp_q;
  assign rsp_hit    = rsp_q && rd_v && (rd_tag == tag_q);
  assign rsp_target = rsp_hit ? rd_tgt  : '0;
  assign rsp_conf   = rsp_hit ? rd_conf : '0;
  assign rsp_repl   = rsp_hit ? rd_repl : '0;

  logic old_hit;
  assign old_hit = o_v && (o_tag == up_tag);

  // Back-pressure blocks new lookups and freezes the response
  assert_hold_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !lk_ready);
  assert_hold_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_target)
                                  && $stable(rsp_conf) && $stable(rsp_repl));
  // Miss responses carry no payload
  assert_miss_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_target == '0 && rsp_conf == 2'd0 && rsp_repl == 2'd0));
  // Target stays while confidence is above its floor
  assert_tgt_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_fire && !up_alloc && old_hit && o_conf != 2'd0) |-> (wr_tgt == o_tgt));
  // Confidence moves by at most one step
  assert_conf_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_fire && !up_alloc && old_hit) |->
      (wr_conf == o_conf || wr_conf == o_conf + 2'd1 || wr_conf == o_conf - 2'd1));
  // Address mode never lowers the replacement value
  assert_addr_repl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_fire && !up_alloc && old_hit && mode_addr) |-> (wr_repl >= o_repl));
  // Mismatching update leaves storage alone
  assert_nohit_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_fire && !up_alloc && !old_hit) |-> !wr_en);
endmodule

// File: tb/dual_hash_target_table_tb.sv
module dual_hash_target_table_tb;
  localparam int DEPTH = 256, IDX_W = 8, TAG_W = 13, HIST_W = 40;

  logic clk = 0, rst_n = 0, mode_addr = 0;
  logic lk_valid = 0, rsp_ready = 1, up_valid = 0, up_alloc = 0;
  logic up_alt_diff = 0, up_alt_ok = 0;
  logic [31:0] lk_pc = 0, up_pc = 0, up_target = 0;
  logic [HIST_W-1:0] lk_hist = 0, up_hist = 0;
  logic lk_ready, rsp_valid, rsp_hit, up_ready;
  logic [31:0] rsp_target;
  logic [1:0] rsp_conf, rsp_repl;

  always #10 clk = ~clk;

  dual_hash_target_table u_dut (
    .clk(clk), .rst_n(rst_n), .mode_addr(mode_addr),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc), .lk_hist(lk_hist),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_target(rsp_target), .rsp_conf(rsp_conf), .rsp_repl(rsp_repl),
    .up_valid(up_valid), .up_ready(up_ready), .up_alloc(up_alloc),
    .up_pc(up_pc), .up_hist(up_hist), .up_target(up_target),
    .up_alt_diff(up_alt_diff), .up_alt_ok(up_alt_ok));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  bit          m_v    [DEPTH];
  logic [12:0] m_tag  [DEPTH];
  logic [31:0] m_tgt  [DEPTH];
  logic [1:0]  m_conf [DEPTH];
  logic [1:0]  m_repl [DEPTH];

  function automatic logic [63:0] fold(logic [HIST_W-1:0] h, int w);
    logic [63:0] r = 0, msk = (64'd1 << w) - 1;
    for (int i = 0; i < HIST_W; i += w) r ^= ({24'd0, h} >> i) & msk;
    return r;
  endfunction

  function automatic int idx_of(logic m, logic [31:0] pc, logic [HIST_W-1:0] h);
    if (m) return int'((pc >> 2) & 32'hff);
    return int'(((pc >> 2) ^ fold(h, IDX_W)) & 64'hff);
  endfunction

  function automatic logic [12:0] tag_of(logic m, logic [31:0] pc, logic [HIST_W-1:0] h);
    logic [63:0] t;
    if (m) t = {32'd0, pc >> (2 + IDX_W)};
    else   t = {32'd0, pc >> 2} ^ fold(h, TAG_W);
    return t[12:0];
  endfunction

  function automatic logic [1:0] up2(logic [1:0] c); return (c == 3) ? c : c + 1; endfunction
  function automatic logic [1:0] dn2(logic [1:0] c); return (c == 0) ? c : c - 1; endfunction

  function automatic logic [36:0] expect_rsp(logic m, logic [31:0] pc, logic [HIST_W-1:0] h);
    int i = idx_of(m, pc, h);
    if (m_v[i] && m_tag[i] == tag_of(m, pc, h)) return {1'b1, m_conf[i], m_repl[i], m_tgt[i]};
    return 37'd0;
  endfunction

  task automatic model_upd(logic m, logic al, logic [31:0] pc, logic [HIST_W-1:0] h,
                           logic [31:0] tg, logic ad, logic ao);
    int i = idx_of(m, pc, h);
    logic [12:0] t = tag_of(m, pc, h);
    bit ok;
    if (al) begin
      m_v[i] = 1; m_tag[i] = t; m_tgt[i] = tg; m_conf[i] = 0; m_repl[i] = 0;
    end else if (m_v[i] && m_tag[i] == t) begin
      ok = (m_tgt[i] == tg);
      if (m) m_repl[i] = up2(m_repl[i]);
      else if (ad) m_repl[i] = ok ? up2(m_repl[i]) : (ao ? dn2(m_repl[i]) : m_repl[i]);
      if (ok) m_conf[i] = up2(m_conf[i]);
      else if (m_conf[i] == 0) m_tgt[i] = tg;
      else m_conf[i] = dn2(m_conf[i]);
    end
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [36:0] got();
    return {rsp_hit, rsp_conf, rsp_repl, rsp_target};
  endfunction

  task automatic do_up(logic al, logic [31:0] pc, logic [HIST_W-1:0] h, logic [31:0] tg,
                       logic ad, logic ao);
    @(negedge clk);
    up_valid = 1; up_alloc = al; up_pc = pc; up_hist = h; up_target = tg;
    up_alt_diff = ad; up_alt_ok = ao;
    model_upd(mode_addr, al, pc, h, tg, ad, ao);
    @(negedge clk);
    up_valid = 0;
  endtask

  task automatic do_lk(string req, logic [31:0] pc, logic [HIST_W-1:0] h);
    logic [36:0] e;
    @(negedge clk);
    lk_valid = 1; lk_pc = pc; lk_hist = h; rsp_ready = 1;
    e = expect_rsp(mode_addr, pc, h);
    @(negedge clk);
    lk_valid = 0;
    chk(req, {27'd0, got()}, {27'd0, e});
  endtask

  localparam logic [31:0] PA = 32'h0040_1234, PB = 32'h0080_5678;
  localparam logic [HIST_W-1:0] HA = 40'h12_3456_789a, HB = 40'h0f_0f0f_0f0f;

  initial begin
    for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    chk("R1 ready", {62'd0, lk_ready, up_ready}, 64'd3);
    do_lk("R1 miss after reset", PA, HA);

    // R5 and R3: allocate in history mode
    mode_addr = 0;
    do_up(1, PA, HA, 32'hAAAA_0001, 0, 0);
    do_lk("R5 alloc visible", PA, HA);
    chk("R5 fields", {27'd0, got()}, {27'd0, 1'b1, 2'd0, 2'd0, 32'hAAAA_0001});
    do_lk("R3 other history", PA, HB);

    // R6 confidence saturates and target replacement
    for (int k = 0; k < 4; k++) do_up(0, PA, HA, 32'hAAAA_0001, 0, 0);
    do_lk("R6 conf saturates at 3", PA, HA);
    chk("R6 conf3", {62'd0, rsp_conf}, 64'd3);
    do_up(0, PA, HA, 32'hBBBB_0002, 0, 0);
    do_lk("R6 wrong keeps target", PA, HA);
    chk("R6 target kept", {32'd0, rsp_target}, {32'd0, 32'hAAAA_0001});
    do_up(0, PA, HA, 32'hBBBB_0002, 0, 0);
    do_up(0, PA, HA, 32'hBBBB_0002, 0, 0);
    do_up(0, PA, HA, 32'hBBBB_0002, 0, 0);
    do_lk("R6 target replaced at floor", PA, HA);
    chk("R6 new target", {32'd0, rsp_target}, {32'd0, 32'hBBBB_0002});

    // R7 history-mode replacement rules
    do_up(0, PA, HA, 32'hBBBB_0002, 0, 0);
    do_lk("R7 no alt diff", PA, HA);
    do_up(0, PA, HA, 32'hBBBB_0002, 1, 0);
    do_up(0, PA, HA, 32'hBBBB_0002, 1, 0);
    do_lk("R7 alt diff and right", PA, HA);
    chk("R7 repl 2", {62'd0, rsp_repl}, 64'd2);
    do_up(0, PA, HA, 32'hCCCC_0003, 1, 1);
    do_lk("R7 alt right", PA, HA);
    chk("R7 repl 1", {62'd0, rsp_repl}, 64'd1);

    // R8 address mode, R4 hash
    mode_addr = 1;
    do_up(1, PB, HA, 32'hDDDD_0004, 0, 0);
    do_lk("R4 history ignored", PB, HB);
    for (int k = 0; k < 5; k++) do_up(0, PB, HB, 32'hEEEE_0005, 0, 0);
    do_lk("R8 repl saturates", PB, HA);
    chk("R8 repl 3", {62'd0, rsp_repl}, 64'd3);

    // R9 same row, different tag
    do_up(0, PB + (32'd1 << (2 + IDX_W)), HA, 32'h1111_0000, 1, 1);
    do_lk("R9 mismatched update ignored", PB, HA);

    // R12 mode change clears nothing
    mode_addr = 0;
    do_lk("R12 history row survives", PA, HA);
    chk("R12 hit", {63'd0, rsp_hit}, 64'd1);

    // R10 same-edge read and write
    begin
      logic [36:0] e_old;
      @(negedge clk);
      lk_valid = 1; lk_pc = PA; lk_hist = HA;
      e_old = expect_rsp(0, PA, HA);
      up_valid = 1; up_alloc = 1; up_pc = PA; up_hist = HA; up_target = 32'h7777_0007;
      model_upd(0, 1, PA, HA, 32'h7777_0007, 0, 0);
      @(negedge clk);
      lk_valid = 0; up_valid = 0;
      chk("R10 old data", {27'd0, got()}, {27'd0, e_old});
      do_lk("R10 new data next", PA, HA);
    end

    // R11 back-pressure
    begin
      logic [36:0] ea, eb;
      @(negedge clk);
      rsp_ready = 0; lk_valid = 1; lk_pc = PA; lk_hist = HA;
      ea = expect_rsp(0, PA, HA);
      @(negedge clk);
      chk("R11 lk_ready low", {63'd0, lk_ready}, 64'd0);
      lk_pc = PB; lk_hist = HB;
      eb = expect_rsp(0, PB, HB);
      @(negedge clk);
      chk("R11 held", {27'd0, got()}, {27'd0, ea});
      rsp_ready = 1;
      @(negedge clk);
      lk_valid = 0;
      chk("R11 next beat", {27'd0, got()}, {27'd0, eb});
      @(negedge clk);
    end

    // constrained random
    begin
      int unsigned seed_dummy = $urandom(32'h5eed);
      logic [31:0] pool [12];
      logic [HIST_W-1:0] hp [4];
      if (seed_dummy == 0) ;
      for (int i = 0; i < 12; i++) pool[i] = {$urandom} & 32'h00ff_fffc;
      for (int i = 0; i < 4; i++) hp[i] = {8'($urandom), 32'($urandom)};
      for (int it = 0; it < 1500; it++) begin
        int op = $urandom % 4;
        logic [31:0] pc = pool[$urandom % 12];
        logic [HIST_W-1:0] h = hp[$urandom % 4];
        logic [31:0] tg = (($urandom % 3) == 0) ? {$urandom} : 32'h100 * ($urandom % 3);
        if (($urandom % 20) == 0) mode_addr = ~mode_addr;
        case (op)
          0: do_up(1, pc, h, tg, 0, 0);
          1: do_up(0, pc, h, tg, 1'($urandom), 1'($urandom));
          default: do_lk(mode_addr ? "R8 R4 random lookup" : "R7 R3 random lookup", pc, h);
        endcase
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule